// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives an SPI serial clock from the main clock through two cascaded dividers. The first is a power-of-two prescaler: a 2-bit divide code selects a division by 2, 4, 8 or 16. The second is a linear baud stage that divides the prescaled clock by 2*(baud+1), where the baud code is legal from 4 to 63. The result is a serial clock whose half period is (2<<div)*(baud+1) main cycles. It ranges from main/20 at the fastest to main/2048 at the slowest.

The generator drives the serial clock line at an idle level chosen by a polarity input. It also produces two one-cycle strobes for a shift engine. One marks the edge on which data should be launched and the other marks the edge on which data should be sampled. A phase input decides which clock edge plays which role. The divide code, baud code, polarity and phase are captured only while the generator is disabled. On enable, the first clock edge comes one full half period later, so no runt pulse appears.

A separate combinational solver converts a requested main-to-serial divide ratio into a legal divide/baud pair. It tries prescaler codes from the smallest upward and takes the first one whose baud value falls in range. Requests that are too fast or too slow are clamped to the nearest legal setting.

Top module: `sck_two_stage_gen`

## Requirements
- R1: While `en_i` is low, `sck_o` takes the value of `cpol_i` one cycle later, and `launch_o` and `sample_o` are low. After reset with `en_i` low, `sck_o` equals `cpol_i` and both strobes are 0.
- R2: Let H = (2 << div) * (brg + 1), using the captured codes. After `en_i` is first seen high at a clock edge, `sck_o` toggles on the H-th edge (counting that edge as the first), and then toggles every H edges while enabled.
- R3: Every enabled toggle of `sck_o` is accompanied, in the same cycle, by exactly one of `launch_o` or `sample_o`. When phase is 0, the edge leaving the idle level is a sample edge and the edge returning to idle is a launch edge. When phase is 1, these roles are swapped. No strobe is high in any other cycle.
- R4: Changes to `div_i`, `brg_i`, `cpol_i` and `cpha_i` made while `en_i` is high do not change the half period or the strobe roles. The captured values are those present at the last edge where `en_i` was low.
- R5: Dropping `en_i` returns `sck_o` to the idle level on the next edge and clears the divider state. A later enable again waits a full H edges before the first toggle.
- R6: The solver computes q(d) = ratio >> (2 + d) for d = 0..3. It selects the lowest d whose q(d) lies in 5..64, and outputs that d with brg = q(d) - 1.
- R7: If ratio >> 2 is below 5, the solver outputs div = 0, brg = 4.
- R8: If no d gives q(d) in 5..64 and R7 does not apply, the solver outputs div = 3, brg = 63.
- R9: The solver's brg output always lies in 4..63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low holds dividers cleared and captures settings |
| div_i | input | 2 | Prescaler code, division by 2 << div_i |
| brg_i | input | 6 | Baud code, 4..63 |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase: 0 samples on the leading edge, 1 launches on it |
| ratio_i | input | RATIO_W | Requested main/serial divide ratio for the solver |
| ratio_div_o | output | 2 | Solver prescaler code |
| ratio_brg_o | output | 6 | Solver baud code |
| sck_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle launch-edge strobe |
| sample_o | output | 1 | One-cycle sample-edge strobe |

## Verification
The timing assertions assume that `brg_i` is at least 4 whenever `en_i` is low, since a smaller captured code would give a half period shorter than the assertion model expects. They also assume that `en_i` is low when reset is released, so that a setting has been captured before the first run. The stimulus only enables the generator after holding it disabled with legal codes for several cycles. It changes the inputs mid-run only to other legal codes, and it drives the solver with ratios that cover each clamp and each prescaler boundary.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;
  localparam int DIV_W = 2;
  localparam int BRG_W = 6;
  localparam int NDIV  = 2 ** DIV_W;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BRG_W-1:0] brg;
    logic             cpol;
    logic             cpha;
  } sck_cfg_t;
endpackage

// File: rtl/sckgen_prescale.sv
module sckgen_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int MAX_P = 2 << (2 ** DIV_W - 1);
  localparam int CNT_W = $clog2(MAX_P);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   period;
  logic             last;

  assign period = (CNT_W+1)'(2) << div_i;
  assign last   = ({1'b0, cnt_q} == period - 1'b1);
  assign tick_o = run_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sckgen_baud.sv
module sckgen_baud #(
  parameter int BRG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             flip_o
);
  logic [BRG_W-1:0] cnt_q;

  assign flip_o = run_i & tick_i & (cnt_q == brg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (flip_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sckgen_solver.sv
module sckgen_solver #(
  parameter int RATIO_W = 24,
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [DIV_W-1:0]   div_o,
  output logic [BRG_W-1:0]   brg_o
);
  localparam int NDIV = 2 ** DIV_W;
  localparam logic [RATIO_W-1:0] LO = RATIO_W'(BRG_MIN + 1);
  localparam logic [RATIO_W-1:0] HI = RATIO_W'(BRG_MAX + 1);

  logic [RATIO_W-1:0] quo [NDIV];
  logic [NDIV-1:0]    fit;

  for (genvar d = 0; d < NDIV; d++) begin : g_cand
    assign quo[d] = ratio_i >> (d + 2);
    assign fit[d] = (quo[d] >= LO) && (quo[d] <= HI);
  end

  always_comb begin
    div_o = DIV_W'(NDIV - 1);
    brg_o = BRG_W'(BRG_MAX);
    if (quo[0] < LO) begin
      div_o = '0;
      brg_o = BRG_W'(BRG_MIN);
    end else begin
      // descending scan so the lowest fitting prescaler wins
      for (int d = NDIV - 1; d >= 0; d--) begin
        if (fit[d]) begin
          div_o = DIV_W'(d);
          brg_o = BRG_W'(quo[d] - 1'b1);
        end
      end
    end
  end
endmodule

// File: rtl/sck_two_stage_gen.sv
module sck_two_stage_gen
  import sckgen_pkg::*;
#(
  parameter int RATIO_W = 24,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [BRG_W-1:0]   brg_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [DIV_W-1:0]   ratio_div_o,
  output logic [BRG_W-1:0]   ratio_brg_o,
  output logic               sck_o,
  output logic               launch_o,
  output logic               sample_o
);
  sck_cfg_t cfg_q;
  logic     tick, flip, leading, smp_edge;
  logic     sck_q, launch_q, sample_q;

  // settings are frozen while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (!en_i) cfg_q <= '{div: div_i, brg: brg_i, cpol: cpol_i, cpha: cpha_i};
  end

  sckgen_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .div_i  (cfg_q.div),
    .tick_o (tick)
  );

  sckgen_baud #(.BRG_W(BRG_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .tick_i (tick),
    .brg_i  (cfg_q.brg),
    .flip_o (flip)
  );

  assign leading  = (sck_q == cfg_q.cpol);
  assign smp_edge = (leading != cfg_q.cpha);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else if (!en_i) begin
      sck_q    <= cpol_i;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      sck_q    <= sck_q ^ flip;
      launch_q <= flip & ~smp_edge;
      sample_q <= flip & smp_edge;
    end
  end

  assign sck_o    = sck_q;
  assign launch_o = launch_q;
  assign sample_o = sample_q;

  sckgen_solver #(
    .RATIO_W (RATIO_W),
    .DIV_W   (DIV_W),
    .BRG_W   (BRG_W),
    .BRG_MIN (BRG_MIN),
    .BRG_MAX (BRG_MAX)
  ) u_solver (
    .ratio_i (ratio_i),
    .div_o   (ratio_div_o),
    .brg_o   (ratio_brg_o)
  );
endmodule

// File: rtl/sckgen_chk.sv
module sckgen_chk #(
  parameter int RATIO_W = 24,
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [DIV_W-1:0]   div_i,
  input logic [BRG_W-1:0]   brg_i,
  input logic               cpol_i,
  input logic               cpha_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic [DIV_W-1:0]   ratio_div_o,
  input logic [BRG_W-1:0]   ratio_brg_o,
  input logic               sck_o,
  input logic               launch_o,
  input logic               sample_o
);
  localparam int HW = (2 ** DIV_W) + BRG_W + 2;

  logic [HW-1:0] h_q, cnt_q;
  logic          cp_q, ph_q;

  // reference half-period counter built from the ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q   <= HW'(2);
      cnt_q <= '0;
      cp_q  <= 1'b0;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      h_q   <= (HW'(2) << div_i) * (HW'(brg_i) + HW'(1));
      cnt_q <= '0;
      cp_q  <= cpol_i;
      ph_q  <= cpha_i;
    end else if (cnt_q == h_q - 1'b1) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1 and R5: idle level follows polarity one cycle after a disabled edge
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sck_o == $past(cpol_i)) && !launch_o && !sample_o);

  assert_half_period_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> ((sck_o != $past(sck_o)) == (cnt_q == '0)));

  assert_strobe_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({launch_o, sample_o}));

  assert_strobe_on_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sck_o != $past(sck_o))) |-> $onehot({launch_o, sample_o}));

  assert_strobe_role_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sck_o != $past(sck_o)) && ($past(sck_o) == cp_q))
      |-> (sample_o == !ph_q));

  assert_brg_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_brg_o >= BRG_W'(BRG_MIN)) && (ratio_brg_o <= BRG_W'(BRG_MAX)));

  assert_fast_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ratio_i >> 2) < RATIO_W'(BRG_MIN + 1))
      |-> (ratio_div_o == '0) && (ratio_brg_o == BRG_W'(BRG_MIN)));

  assert_slow_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ratio_i >> (2 ** DIV_W + 1)) > RATIO_W'(BRG_MAX + 1))
      |-> (ratio_div_o == '1) && (ratio_brg_o == BRG_W'(BRG_MAX)));
endmodule

bind sck_two_stage_gen sckgen_chk #(
  .RATIO_W (RATIO_W),
  .DIV_W   (sckgen_pkg::DIV_W),
  .BRG_W   (sckgen_pkg::BRG_W),
  .BRG_MIN (BRG_MIN),
  .BRG_MAX (BRG_MAX)
) u_chk (.*);

// File: tb/tb_sck_two_stage_gen.sv
module tb_sck_two_stage_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  div_i = '0;
  logic [5:0]  brg_i = 6'd4;
  logic        cpol_i = 1'b0;
  logic        cpha_i = 1'b0;
  logic [23:0] ratio_i = '0;
  logic [1:0]  ratio_div_o;
  logic [5:0]  ratio_brg_o;
  logic        sck_o, launch_o, sample_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sck_two_stage_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .div_i(div_i), .brg_i(brg_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .ratio_i(ratio_i),
    .ratio_div_o(ratio_div_o), .ratio_brg_o(ratio_brg_o),
    .sck_o(sck_o), .launch_o(launch_o), .sample_o(sample_o)
  );

  // {ratio, expected div, expected brg}
  localparam logic [31:0] VEC [0:12] = '{
    {24'd0,       2'd0, 6'd4 },   // R7
    {24'd19,      2'd0, 6'd4 },   // R7
    {24'd20,      2'd0, 6'd4 },   // R6 lower bound
    {24'd100,     2'd0, 6'd24},   // R6
    {24'd259,     2'd0, 6'd63},   // R6 top of div 0
    {24'd260,     2'd1, 6'd31},   // R6 rolls to div 1
    {24'd519,     2'd1, 6'd63},   // R6
    {24'd520,     2'd2, 6'd31},   // R6
    {24'd1000,    2'd2, 6'd61},   // R6
    {24'd2000,    2'd3, 6'd61},   // R6
    {24'd2079,    2'd3, 6'd63},   // R6 slowest legal
    {24'd2080,    2'd3, 6'd63},   // R8
    {24'd1000000, 2'd3, 6'd63}    // R8
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_flip(output int n);
    logic prev;
    prev = sck_o;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (sck_o == prev && n < 4000);
  endtask

  task automatic run_case(input int d, input int b, input bit cp, input bit ph);
    int n, h;
    h = (2 << d) * (b + 1);
    @(negedge clk);
    en_i = 1'b0; div_i = 2'(d); brg_i = 6'(b); cpol_i = cp; cpha_i = ph;
    repeat (2) @(negedge clk);
    chk("R1 idle level", sck_o, cp);
    chk("R1 idle strobes", {launch_o, sample_o}, 0);
    en_i = 1'b1;
    wait_flip(n);
    chk("R2 first half period", n, h);
    chk("R3 leading sample", sample_o, !ph);
    chk("R3 leading launch", launch_o, ph);
    // R4: mid-run changes must be ignored
    div_i = 2'(3 - d); brg_i = 6'd50; cpol_i = !cp; cpha_i = !ph;
    wait_flip(n);
    chk("R4 half period held", n, h);
    chk("R3 trailing sample", sample_o, ph);
    chk("R3 trailing launch", launch_o, !ph);
    chk("R3 trailing level", sck_o, cp);
    @(negedge clk);
    chk("R3 strobe width", {launch_o, sample_o}, 0);
    wait_flip(n);
    chk("R4 roles held", sample_o, !ph);
    // R5: disable mid-phase, restore idle, restart with full half period
    div_i = 2'(d); brg_i = 6'(b); cpol_i = cp; cpha_i = ph;
    en_i = 1'b0;
    @(negedge clk);
    chk("R5 back to idle", sck_o, cp);
    en_i = 1'b1;
    wait_flip(n);
    chk("R5 restart half period", n, h);
    @(negedge clk);
    en_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset sck", sck_o, 0);
    chk("R1 reset strobes", {launch_o, sample_o}, 0);

    for (int i = 0; i < 13; i++) begin
      ratio_i = VEC[i][31:8];
      #1;
      chk($sformatf("R6 div ratio=%0d", ratio_i), ratio_div_o, VEC[i][7:6]);
      chk($sformatf("R6 brg ratio=%0d", ratio_i), ratio_brg_o, VEC[i][5:0]);
      chk("R9 brg range", (ratio_brg_o >= 4 && ratio_brg_o <= 63), 1);
    end

    run_case(0, 4, 1'b0, 1'b0);   // fastest, main/20
    run_case(1, 5, 1'b1, 1'b1);
    run_case(2, 10, 1'b1, 1'b0);
    run_case(3, 63, 1'b0, 1'b1);  // slowest, main/2048

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule